// File: doc/BRIEF.md
# Single-Operand Bit Manipulation Unit

This unit is the execute stage for the one-register instruction group of a 32-bit processor. It takes the value of the named register, the current condition bit C and a 4-bit sub-opcode with one group-select bit. In the same cycle it returns a new register value, an optional result bound for register r1, a new C bit and separate write strobes for the register, r1 and C.

The group covers find-first-one, bit reversal, the byte extracts, zero and sign extension, increment and decrement by C or by its inverse, moves of C into a register, clears gated by C, the decrement-and-test forms, the all-bytes-nonzero test, absolute value and bitwise NOT. The register file and the decoder drive the inputs and act on the strobes. When a strobe is low, the matching output carries a fixed neutral value: the register output repeats the input, r1 reads zero, and C repeats the incoming C.

Top module: `bitop_unit`

## Requirements
- R1: With grp=0, op=4'hE (find-first-one), the register is written with the count of zero bits above the highest set bit, counted down from bit 31; an input of zero gives 32.
- R2: With grp=0, op=4'hF (reverse), the register is written with its bits mirrored, bit i moving to bit 31-i.
- R3: With grp=1 and op 0,1,2,3, r1 is written with byte 0 (bits 7:0), byte 1, byte 2 or byte 3 (bits 31:24) of the input, zero-extended. C is written with (input != 0), and the named register is not written.
- R4: With grp=1, op 4/5/6/7, the register is written with the low byte zero-extended, the low byte sign-extended, the low half zero-extended, or the low half sign-extended, respectively.
- R5: With grp=1, op 8/4'hA/4'hB, the register is written with input minus 1. C is written with the signed result being below zero, above zero, or nonzero, respectively.
- R6: With grp=1, op 9, C is written with 1 only when all four bytes of the input are nonzero, and the register is not written.
- R7: With grp=1, op 4'hC, the register is cleared and written only when C=1; with op 4'hD, only when C=0. Otherwise nothing is written.
- R8: With grp=0, op 8/9/4'hA/4'hB, the register is written with input minus C, input minus not-C, input plus C, and input plus not-C, respectively.
- R9: With grp=0, op 2 the register is written with C zero-extended; with op 3 it is written with the inverse of C.
- R10: With grp=1, op 4'hE, the register is written with its two's complement when bit 31 is set and with itself otherwise, so 32'h80000000 stays unchanged.
- R11: With grp=1, op 4'hF, the register is written with its bitwise inverse.
- R12: Every operation that does not define a C result keeps c_we low and c_out equal to c_in.
- R13: The group-0 codes 0, 1, 4, 5, 6, 7, 4'hC and 4'hD assert no strobe. A deasserted strobe leaves rd_out equal to rd_in, r1_out zero and c_out equal to c_in.
- R14: All outputs are a combinational function of the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| grp | input | 1 | Group select: 0 for the move/count group, 1 for the extract/test group |
| op | input | 4 | Sub-opcode within the group |
| rd_in | input | 32 | Current value of the named register |
| c_in | input | 1 | Current condition bit |
| rd_out | output | 32 | New value for the named register |
| rd_we | output | 1 | Write strobe for the named register |
| r1_out | output | 32 | Value for register r1 |
| r1_we | output | 1 | Write strobe for r1 |
| c_out | output | 1 | New condition bit |
| c_we | output | 1 | Write strobe for the condition bit |

## Verification
Two results can leave the unit in the same cycle. A byte extract writes r1 and C together, and a decrement-and-test writes the named register and C together. Each vector in the table gives all three strobes and all three values. A collision case therefore fails when either half is wrong, when the named register is written alongside r1, or when a C-gated clear writes C. Extracts from zero and nonzero sources, and decrement-tests across the sign boundary (0, 1 and 32'h80000000), push both halves to change together.

// File: rtl/bitop_unit.sv
module bitop_unit (
  input  logic        grp,
  input  logic [3:0]  op,
  input  logic [31:0] rd_in,
  input  logic        c_in,
  output logic [31:0] rd_out,
  output logic        rd_we,
  output logic [31:0] r1_out,
  output logic        r1_we,
  output logic        c_out,
  output logic        c_we
);

  function automatic logic [31:0] lead_zeros(input logic [31:0] v);
    logic [31:0] n;
    logic        hit;
    n   = 32'd0;
    hit = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      if (!hit && v[i]) hit = 1'b1;
      if (!hit) n = n + 32'd1;
    end
    return n;
  endfunction

  function automatic logic [31:0] mirror(input logic [31:0] v);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) m[i] = v[31-i];
    return m;
  endfunction

  logic [31:0] dec1;
  logic [7:0]  sel_byte;
  logic        c_new;
  logic        all_bytes;

  assign dec1      = rd_in - 32'd1;
  assign all_bytes = (|rd_in[31:24]) & (|rd_in[23:16]) & (|rd_in[15:8]) & (|rd_in[7:0]);

  always_comb begin
    case (op[1:0])
      2'd0:    sel_byte = rd_in[7:0];
      2'd1:    sel_byte = rd_in[15:8];
      2'd2:    sel_byte = rd_in[23:16];
      default: sel_byte = rd_in[31:24];
    endcase
  end

  always_comb begin
    rd_out = rd_in;
    rd_we  = 1'b0;
    r1_out = 32'd0;
    r1_we  = 1'b0;
    c_new  = c_in;
    c_we   = 1'b0;
    if (!grp) begin
      case (op)
        4'h2: begin rd_out = {31'd0, c_in};  rd_we = 1'b1; end
        4'h3: begin rd_out = {31'd0, !c_in}; rd_we = 1'b1; end
        4'h8: begin rd_out = rd_in - {31'd0, c_in};  rd_we = 1'b1; end
        4'h9: begin rd_out = rd_in - {31'd0, !c_in}; rd_we = 1'b1; end
        4'hA: begin rd_out = rd_in + {31'd0, c_in};  rd_we = 1'b1; end
        4'hB: begin rd_out = rd_in + {31'd0, !c_in}; rd_we = 1'b1; end
        4'hE: begin rd_out = lead_zeros(rd_in); rd_we = 1'b1; end
        4'hF: begin rd_out = mirror(rd_in);     rd_we = 1'b1; end
        default: ;
      endcase
    end else begin
      case (op)
        4'h0, 4'h1, 4'h2, 4'h3: begin
          r1_out = {24'd0, sel_byte};
          r1_we  = 1'b1;
          c_new  = |rd_in;
          c_we   = 1'b1;
        end
        4'h4: begin rd_out = {24'd0, rd_in[7:0]};             rd_we = 1'b1; end
        4'h5: begin rd_out = {{24{rd_in[7]}}, rd_in[7:0]};    rd_we = 1'b1; end
        4'h6: begin rd_out = {16'd0, rd_in[15:0]};            rd_we = 1'b1; end
        4'h7: begin rd_out = {{16{rd_in[15]}}, rd_in[15:0]};  rd_we = 1'b1; end
        4'h8: begin rd_out = dec1; rd_we = 1'b1; c_new = dec1[31]; c_we = 1'b1; end
        4'h9: begin c_new = all_bytes; c_we = 1'b1; end
        4'hA: begin rd_out = dec1; rd_we = 1'b1; c_new = !dec1[31] && (dec1 != 32'd0); c_we = 1'b1; end
        4'hB: begin rd_out = dec1; rd_we = 1'b1; c_new = (dec1 != 32'd0); c_we = 1'b1; end
        4'hC: if (c_in)  begin rd_out = 32'd0; rd_we = 1'b1; end
        4'hD: if (!c_in) begin rd_out = 32'd0; rd_we = 1'b1; end
        4'hE: begin rd_out = rd_in[31] ? (~rd_in + 32'd1) : rd_in; rd_we = 1'b1; end
        default: begin rd_out = ~rd_in; rd_we = 1'b1; end
      endcase
    end
  end

  assign c_out = c_new;

  always_comb begin
    if (!$isunknown({grp, op, rd_in, c_in})) begin
      AST_EXTRACT_NO_RD: assert (!(r1_we && rd_we)); // R3
      AST_C_HOLD: assert (c_we || (c_out == c_in)); // R12
      AST_FF1_RANGE: assert (!(!grp && op == 4'hE) || rd_out <= 32'd32); // R1
      AST_ABS_SIGN: assert (!(grp && op == 4'hE && rd_out[31]) || rd_in == 32'h8000_0000); // R10
      AST_DECNE_C: assert (!(grp && op == 4'hB) || (c_out == (rd_out != 32'd0))); // R5
      AST_QUIET_R1: assert (r1_we || r1_out == 32'd0); // R13
      AST_CLEAR_GATE: assert (!(grp && op == 4'hC) || (rd_we == c_in && !c_we)); // R7
    end
  end

endmodule

// File: tb/tb_bitop_unit.sv
`timescale 1ns/1ps
module tb_bitop_unit;

  typedef struct packed {
    logic        g;
    logic [3:0]  op;
    logic [31:0] rd;
    logic        c;
    logic [31:0] xrd;
    logic        xrdwe;
    logic [31:0] xr1;
    logic        xr1we;
    logic        xc;
    logic        xcwe;
    logic [7:0]  req;
  } vec_t;

  localparam int N = 36;
  localparam vec_t TBL [N] = '{
    '{1'b0, 4'hE, 32'h0001_0000, 1'b0, 32'd15,          1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1
    '{1'b0, 4'hE, 32'h0000_0000, 1'b1, 32'd32,          1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd1},  // R1
    '{1'b0, 4'hE, 32'h8000_0000, 1'b0, 32'd0,           1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1
    '{1'b0, 4'hF, 32'h0000_0001, 1'b0, 32'h8000_0000,   1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd2},  // R2
    '{1'b0, 4'hF, 32'h1234_5678, 1'b1, 32'h1E6A_2C48,   1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd2},  // R2
    '{1'b1, 4'h0, 32'h1122_3344, 1'b0, 32'h1122_3344,   1'b0, 32'h44, 1'b1, 1'b1, 1'b1, 8'd3}, // R3
    '{1'b1, 4'h3, 32'h1122_3344, 1'b0, 32'h1122_3344,   1'b0, 32'h11, 1'b1, 1'b1, 1'b1, 8'd3}, // R3
    '{1'b1, 4'h1, 32'h0000_0000, 1'b1, 32'h0,           1'b0, 32'h00, 1'b1, 1'b0, 1'b1, 8'd3}, // R3
    '{1'b1, 4'h2, 32'hAABB_CCDD, 1'b0, 32'hAABB_CCDD,   1'b0, 32'hBB, 1'b1, 1'b1, 1'b1, 8'd3}, // R3
    '{1'b1, 4'h4, 32'hFFFF_FF80, 1'b0, 32'h0000_0080,   1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4
    '{1'b1, 4'h5, 32'h0000_0080, 1'b1, 32'hFFFF_FF80,   1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd4},  // R4
    '{1'b1, 4'h6, 32'h1234_8765, 1'b0, 32'h0000_8765,   1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4
    '{1'b1, 4'h7, 32'h0000_8000, 1'b0, 32'hFFFF_8000,   1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd4},  // R4
    '{1'b1, 4'h8, 32'h0000_0000, 1'b0, 32'hFFFF_FFFF,   1'b1, 32'd0, 1'b0, 1'b1, 1'b1, 8'd5},  // R5
    '{1'b1, 4'h8, 32'h0000_0005, 1'b1, 32'h0000_0004,   1'b1, 32'd0, 1'b0, 1'b0, 1'b1, 8'd5},  // R5
    '{1'b1, 4'hA, 32'h0000_0001, 1'b1, 32'h0000_0000,   1'b1, 32'd0, 1'b0, 1'b0, 1'b1, 8'd5},  // R5
    '{1'b1, 4'hA, 32'h8000_0000, 1'b0, 32'h7FFF_FFFF,   1'b1, 32'd0, 1'b0, 1'b1, 1'b1, 8'd5},  // R5
    '{1'b1, 4'hB, 32'h0000_0001, 1'b1, 32'h0000_0000,   1'b1, 32'd0, 1'b0, 1'b0, 1'b1, 8'd5},  // R5
    '{1'b1, 4'hB, 32'h0000_0002, 1'b0, 32'h0000_0001,   1'b1, 32'd0, 1'b0, 1'b1, 1'b1, 8'd5},  // R5
    '{1'b1, 4'h9, 32'h0101_0101, 1'b0, 32'h0101_0101,   1'b0, 32'd0, 1'b0, 1'b1, 1'b1, 8'd6},  // R6
    '{1'b1, 4'h9, 32'h0100_0101, 1'b1, 32'h0100_0101,   1'b0, 32'd0, 1'b0, 1'b0, 1'b1, 8'd6},  // R6
    '{1'b1, 4'hC, 32'h0000_0055, 1'b1, 32'h0000_0000,   1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd7},  // R7
    '{1'b1, 4'hC, 32'h0000_0055, 1'b0, 32'h0000_0055,   1'b0, 32'd0, 1'b0, 1'b0, 1'b0, 8'd7},  // R7
    '{1'b1, 4'hD, 32'h0000_0055, 1'b0, 32'h0000_0000,   1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd7},  // R7
    '{1'b1, 4'hD, 32'h0000_0055, 1'b1, 32'h0000_0055,   1'b0, 32'd0, 1'b0, 1'b1, 1'b0, 8'd7},  // R7
    '{1'b0, 4'h8, 32'd10,        1'b1, 32'd9,           1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8
    '{1'b0, 4'h9, 32'd10,        1'b1, 32'd10,          1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8
    '{1'b0, 4'hA, 32'd10,        1'b1, 32'd11,          1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd8},  // R8
    '{1'b0, 4'hB, 32'd10,        1'b0, 32'd11,          1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd8},  // R8
    '{1'b0, 4'h2, 32'h0000_1234, 1'b1, 32'd1,           1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd9},  // R9
    '{1'b0, 4'h3, 32'h0000_1234, 1'b1, 32'd0,           1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd9},  // R9
    '{1'b1, 4'hE, 32'hFFFF_FFFB, 1'b0, 32'd5,           1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd10}, // R10
    '{1'b1, 4'hE, 32'h8000_0000, 1'b0, 32'h8000_0000,   1'b1, 32'd0, 1'b0, 1'b0, 1'b0, 8'd10}, // R10
    '{1'b1, 4'hE, 32'd7,         1'b1, 32'd7,           1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd10}, // R10
    '{1'b1, 4'hF, 32'h0F0F_0000, 1'b1, 32'hF0F0_FFFF,   1'b1, 32'd0, 1'b0, 1'b1, 1'b0, 8'd11}, // R11 R12
    '{1'b0, 4'h0, 32'h0000_0099, 1'b1, 32'h0000_0099,   1'b0, 32'd0, 1'b0, 1'b1, 1'b0, 8'd13}  // R13
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        grp;
  logic [3:0]  op;
  logic [31:0] rd_in;
  logic        c_in;
  logic [31:0] rd_out;
  logic        rd_we;
  logic [31:0] r1_out;
  logic        r1_we;
  logic        c_out;
  logic        c_we;
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;

  bitop_unit dut (
    .grp(grp), .op(op), .rd_in(rd_in), .c_in(c_in),
    .rd_out(rd_out), .rd_we(rd_we), .r1_out(r1_out), .r1_we(r1_we),
    .c_out(c_out), .c_we(c_we)
  );

  task automatic check(input int req, input logic [31:0] xrd, input logic xrdwe,
                       input logic [31:0] xr1, input logic xr1we,
                       input logic xc, input logic xcwe);
    logic [99:0] act, exp;
    act = {rd_out, rd_we, r1_out, r1_we, c_out, c_we, 2'b0};
    exp = {xrd, xrdwe, xr1, xr1we, xc, xcwe, 2'b0};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d grp=%0b op=%h rd_in=%h c_in=%0b : act rd=%h/%0b r1=%h/%0b c=%0b/%0b exp rd=%h/%0b r1=%h/%0b c=%0b/%0b",
               req, grp, op, rd_in, c_in, rd_out, rd_we, r1_out, r1_we, c_out, c_we,
               xrd, xrdwe, xr1, xr1we, xc, xcwe);
    end
  endtask

  task automatic drive(input logic g, input logic [3:0] o, input logic [31:0] r, input logic c);
    @(posedge clk);
    #1;
    grp = g; op = o; rd_in = r; c_in = c;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    grp = 1'b0; op = 4'h0; rd_in = 32'd0; c_in = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13: idle code with zero inputs after reset asserts no strobe
    check(13, 32'd0, 1'b0, 32'd0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < N; i++) begin
      drive(TBL[i].g, TBL[i].op, TBL[i].rd, TBL[i].c);
      check(int'(TBL[i].req), TBL[i].xrd, TBL[i].xrdwe, TBL[i].xr1, TBL[i].xr1we, TBL[i].xc, TBL[i].xcwe);
    end

    // R13: every unassigned group-0 code writes nothing, passes rd and c through
    for (int k = 0; k < 16; k++) begin
      if (k == 0 || k == 1 || (k >= 4 && k <= 7) || k == 12 || k == 13) begin
        drive(1'b0, 4'(k), 32'hCAFE_0000 + 32'(k), k[0]);
        check(13, 32'hCAFE_0000 + 32'(k), 1'b0, 32'd0, 1'b0, k[0], 1'b0);
      end
    end

    // R12: non-C ops with both C values keep C and no C strobe
    drive(1'b1, 4'h4, 32'h0000_0001, 1'b1);
    check(12, 32'h1, 1'b1, 32'd0, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 4'hF, 32'h0000_0000, 1'b0);
    check(12, 32'h0, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0);

    // R1: single bit sweep of find-first-one
    for (int b = 0; b < 32; b++) begin
      drive(1'b0, 4'hE, 32'd1 << b, 1'b0);
      check(1, 32'(31 - b), 1'b1, 32'd0, 1'b0, 1'b0, 1'b0);
    end

    // R14: outputs follow an input change with no clock edge in between
    @(posedge clk); #1;
    grp = 1'b1; op = 4'hF; rd_in = 32'h0000_FFFF; c_in = 1'b0;
    #1;
    check(14, 32'hFFFF_0000, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0);
    rd_in = 32'hFFFF_FFFF;
    #1;
    check(14, 32'h0000_0000, 1'b1, 32'd0, 1'b0, 1'b0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule